// File: doc/BRIEF.md
# Level-Sensitive Interrupt Aggregator

The block gathers thirty-two active-high, level-sensitive interrupt lines into a single request toward a parent interrupt controller. Each line first crosses into the local clock domain through a two-stage synchroniser. A per-source enable register then gates the synchronised lines. The gated lines are ORed into one registered output. Nothing is latched: a source stays pending only while its line is high and its enable is set. Software clears a request at the device that raised it, never inside this block.

Software sees four word registers through a simple single-cycle register port. Reads are combinational from the address. A write takes effect at the clock edge where the write enable is high. One register shows the gated pending view and one shows the synchronised line levels. Two write-only command words change the enables. A one written to the first sets the matching enable. A one written to the second clears it. A zero bit in either word leaves that enable as it was. Reading either command word returns the current enable register.

Top module: `irq_aggregator`

## Requirements
- R1: After synchronous reset every enable is 0, the pending view at offset 0x0 reads 0 and `irq_out` is 0.
- R2: Bit n of the word at offset 0x4 equals the level of `irq_in[n]` as it was two rising clock edges earlier, with no masking.
- R3: Bit n of the word at offset 0x0 is 1 exactly when bit n of offset 0x4 is 1 and enable n is set.
- R4: A write to offset 0x8 sets every enable whose write-data bit is 1 and leaves every enable whose bit is 0 unchanged.
- R5: A write to offset 0xC clears every enable whose write-data bit is 1 and leaves every enable whose bit is 0 unchanged.
- R6: A read of offset 0x8 or of offset 0xC returns the current enable register, with enable n in bit n.
- R7: A read of any address other than 0x0, 0x4, 0x8 and 0xC returns 0. A write to any address other than 0x8 and 0xC leaves the enables unchanged. This covers 0x0, 0x4, 0x10 to 0x3C and addresses whose two low bits are not zero.
- R8: `irq_out` equals the OR of all bits of the pending view as it was one clock edge earlier. A change on an input therefore reaches `irq_out` three edges later, and an enable write reaches it one edge after the write edge.
- R9: A source is not held once its line falls. When `irq_in[n]` returns low, pending bit n clears, and `irq_out` falls if no other source is pending, with no acknowledge access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 32 | Level-sensitive interrupt lines, source n on bit n |
| bus_addr | input | 6 | Byte address of the register access |
| bus_we | input | 1 | Write strobe, sampled at the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_out | output | 1 | Combined request toward the parent controller |

## Verification
A corrupted enable bit shows up at once, in the same cycle, on a read of offset 0x8, 0xC or 0x0. On `irq_out` it shows one edge later, but only while the affected line is high. For that reason the bench compares the enable readback against its own model after every operation, rather than relying on `irq_out`. A wrong synchroniser depth shows as a shift of the raw view against the drive time. The bench samples raw, pending and output at the exact edge counts of R2 and R8, so a missing or extra stage shows up as a mismatch one cycle early or late. Faults in decoding address aliases and in priority show as enables changed by writes that should be ignored.

// File: rtl/irqagg_pkg.sv
`timescale 1ns/1ps
package irqagg_pkg;

    localparam int unsigned NUM_SRC   = 32;
    localparam int unsigned DATA_W    = 32;
    localparam int unsigned SYNC_DEPTH = 2;

    // Register selected by address bits [3:2]
    typedef enum logic [1:0] {
        SEL_PENDING = 2'd0,
        SEL_LEVEL   = 2'd1,
        SEL_ENSET   = 2'd2,
        SEL_ENCLR   = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic     hit;
        reg_sel_e sel;
    } addr_dec_t;

    typedef struct packed {
        logic [NUM_SRC-1:0] set_bits;
        logic [NUM_SRC-1:0] clr_bits;
    } en_cmd_t;

    // Decode a zero-extended byte address into a register selection.
    function automatic addr_dec_t decode_addr(input logic [31:0] byte_addr);
        addr_dec_t d;
        d.hit = (byte_addr[31:4] == '0) && (byte_addr[1:0] == 2'b00);
        d.sel = reg_sel_e'(byte_addr[3:2]);
        return d;
    endfunction

    // Turn a bus write into an enable command; only the command words act.
    function automatic en_cmd_t build_cmd(input addr_dec_t d, input logic we,
                                          input logic [NUM_SRC-1:0] data);
        en_cmd_t c;
        c.set_bits = (we && d.hit && d.sel == SEL_ENSET) ? data : '0;
        c.clr_bits = (we && d.hit && d.sel == SEL_ENCLR) ? data : '0;
        return c;
    endfunction

endpackage

// File: rtl/irqagg_sync.sv
`timescale 1ns/1ps
module irqagg_sync #(
    parameter int unsigned WIDTH  = irqagg_pkg::NUM_SRC,
    parameter int unsigned STAGES = irqagg_pkg::SYNC_DEPTH
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain_q[s] <= '0;
                    else     chain_q[s] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain_q[s] <= '0;
                    else     chain_q[s] <= chain_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_out = chain_q[STAGES-1];

endmodule

// File: rtl/irqagg_enable.sv
`timescale 1ns/1ps
module irqagg_enable #(
    parameter int unsigned WIDTH = irqagg_pkg::NUM_SRC
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] set_bits,
    input  logic [WIDTH-1:0] clr_bits,
    output logic [WIDTH-1:0] en_q
);

    logic [WIDTH-1:0] en_d;

    // A clear wins over a set landing on the same bit in one cycle.
    always_comb begin
        en_d = (en_q | set_bits) & ~clr_bits;
    end

    always_ff @(posedge clk) begin
        if (rst) en_q <= '0;
        else     en_q <= en_d;
    end

endmodule

// File: rtl/irqagg_combine.sv
`timescale 1ns/1ps
module irqagg_combine #(
    parameter int unsigned WIDTH = irqagg_pkg::NUM_SRC
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] level,
    input  logic [WIDTH-1:0] enable,
    output logic [WIDTH-1:0] pending,
    output logic             req_q
);

    always_comb begin
        pending = level & enable;
    end

    always_ff @(posedge clk) begin
        if (rst) req_q <= 1'b0;
        else     req_q <= |pending;
    end

endmodule

// File: rtl/irq_aggregator.sv
`timescale 1ns/1ps
module irq_aggregator
    import irqagg_pkg::*;
#(
    parameter int unsigned N      = NUM_SRC,
    parameter int unsigned DW     = DATA_W,
    parameter int unsigned ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N-1:0]      irq_in,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    output logic              irq_out
);

    localparam int unsigned PAD_W = 32 - ADDR_W;

    addr_dec_t    dec;
    en_cmd_t      cmd;
    logic [N-1:0] raw_q;
    logic [N-1:0] en_q;
    logic [N-1:0] pend;

    always_comb begin
        dec = decode_addr({{PAD_W{1'b0}}, bus_addr});
        cmd = build_cmd(dec, bus_we, bus_wdata[N-1:0]);
    end

    irqagg_sync #(.WIDTH(N), .STAGES(SYNC_DEPTH)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (irq_in),
        .sync_out (raw_q)
    );

    irqagg_enable #(.WIDTH(N)) u_enable (
        .clk      (clk),
        .rst      (rst),
        .set_bits (cmd.set_bits),
        .clr_bits (cmd.clr_bits),
        .en_q     (en_q)
    );

    irqagg_combine #(.WIDTH(N)) u_combine (
        .clk     (clk),
        .rst     (rst),
        .level   (raw_q),
        .enable  (en_q),
        .pending (pend),
        .req_q   (irq_out)
    );

    always_comb begin
        bus_rdata = '0;
        if (dec.hit) begin
            unique case (dec.sel)
                SEL_PENDING: bus_rdata = DW'(pend);
                SEL_LEVEL:   bus_rdata = DW'(raw_q);
                SEL_ENSET,
                SEL_ENCLR:   bus_rdata = DW'(en_q);
                default:     bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/irqagg_chk.sv
`timescale 1ns/1ps
module irqagg_chk #(
    parameter int unsigned N      = 32,
    parameter int unsigned DW     = 32,
    parameter int unsigned ADDR_W = 6
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [DW-1:0]     bus_wdata,
    input logic [DW-1:0]     bus_rdata,
    input logic              irq_out,
    input logic [N-1:0]      raw,
    input logic [N-1:0]      en
);

    localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(6'h00);
    localparam logic [ADDR_W-1:0] A_SET  = ADDR_W'(6'h08);
    localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(6'h0C);

    // R4
    p_set_r4: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == A_SET) |=> ((en & $past(bus_wdata[N-1:0])) == $past(bus_wdata[N-1:0])));

    // R5
    p_clear_r5: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == A_CLR) |=> ((en & $past(bus_wdata[N-1:0])) == '0));

    // R7
    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !(bus_we && (bus_addr == A_SET || bus_addr == A_CLR)) |=> $stable(en));

    // R3
    p_pending_r3: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == A_PEND) |-> (bus_rdata == DW'(raw & en)));

    // R6
    p_readback_r6: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == A_SET || bus_addr == A_CLR) |-> (bus_rdata == DW'(en)));

    // R8
    p_out_r8: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (irq_out == (|$past(raw & en))));

endmodule

bind irq_aggregator irqagg_chk #(.N(N), .DW(DW), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_out   (irq_out),
    .raw       (raw_q),
    .en        (en_q)
);

// File: tb/tb_irq_aggregator.sv
`timescale 1ns/1ps
module tb_irq_aggregator;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] irq_in = '0;
    logic [5:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_out;

    int checks = 0;
    int errors = 0;
    logic [31:0] en_m = '0;

    always #10 clk = ~clk;

    irq_aggregator dut (
        .clk(clk), .rst(rst), .irq_in(irq_in), .bus_addr(bus_addr),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_out(irq_out)
    );

    function automatic logic [31:0] exp_pend(input logic [31:0] lv, input logic [31:0] en);
        return lv & en;
    endfunction

    function automatic logic [31:0] next_en(input logic [31:0] en, input logic [5:0] a,
                                            input logic [31:0] d);
        if (a == 6'h08) return en | d;
        if (a == 6'h0C) return en & ~d;
        return en;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
        en_m = next_en(en_m, a, d);
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic settle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic check_all(input string tag);
        logic [31:0] d;
        rd(6'h04, d); chk({tag, " R2 raw"}, d, irq_in);
        rd(6'h00, d); chk({tag, " R3 pending"}, d, exp_pend(irq_in, en_m));
        rd(6'h08, d); chk({tag, " R6 readback set"}, d, en_m);
        rd(6'h0C, d); chk({tag, " R6 readback clr"}, d, en_m);
        chk({tag, " R8 out"}, {31'd0, irq_out}, {31'd0, |exp_pend(irq_in, en_m)});
    endtask

    initial begin : watchdog
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : stim
        logic [31:0] d;
        void'($urandom(32'd20240607));
        settle(3);
        @(negedge clk); rst = 1'b0;

        // R1 reset state
        rd(6'h08, d); chk("R1 enables", d, 32'h0);
        rd(6'h00, d); chk("R1 pending", d, 32'h0);
        chk("R1 out", {31'd0, irq_out}, 32'h0);

        // R2 two-edge latency, R8 three-edge output latency
        wr(6'h08, 32'h0000_0010);
        @(negedge clk); irq_in = 32'h0000_0010;
        @(negedge clk);
        rd(6'h04, d); chk("R2 raw after one edge", d, 32'h0);
        @(negedge clk);
        rd(6'h04, d); chk("R2 raw after two edges", d, 32'h10);
        chk("R8 out not yet", {31'd0, irq_out}, 32'h0);
        @(negedge clk);
        chk("R8 out after three edges", {31'd0, irq_out}, 32'h1);

        // R9 level drop releases pending and output
        @(negedge clk); irq_in = '0;
        settle(3);
        rd(6'h00, d); chk("R9 pending released", d, 32'h0);
        chk("R9 out released", {31'd0, irq_out}, 32'h0);

        // R8 enable write reaches output one edge after the write edge
        @(negedge clk); irq_in = 32'h8000_0001;
        settle(3);
        check_all("masked high");
        @(negedge clk);
        bus_addr = 6'h08; bus_wdata = 32'h8000_0000; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; en_m = next_en(en_m, 6'h08, 32'h8000_0000);
        chk("R8 out one edge after write, still old", {31'd0, irq_out}, 32'h0);
        @(negedge clk);
        chk("R8 out after enable", {31'd0, irq_out}, 32'h1);

        // R4 / R5 zero bits leave enables unchanged
        wr(6'h08, 32'h0000_0F00);
        rd(6'h08, d); chk("R4 set keeps others", d, 32'h8000_0F10);
        wr(6'h0C, 32'h0000_0300);
        rd(6'h0C, d); chk("R5 clear keeps others", d, 32'h8000_0C10);

        // R7 ignored writes and zero reads
        wr(6'h00, 32'hFFFF_FFFF);
        wr(6'h04, 32'hFFFF_FFFF);
        wr(6'h10, 32'hFFFF_FFFF);
        wr(6'h3C, 32'h0000_0000);
        wr(6'h09, 32'hFFFF_FFFF);
        wr(6'h0D, 32'hFFFF_FFFF);
        rd(6'h08, d); chk("R7 enables unchanged", d, 32'h8000_0C10);
        rd(6'h10, d); chk("R7 read 0x10", d, 32'h0);
        rd(6'h3C, d); chk("R7 read 0x3C", d, 32'h0);
        rd(6'h09, d); chk("R7 read misaligned", d, 32'h0);
        settle(2);
        check_all("after ignored writes");

        // Random mix
        for (int i = 0; i < 300; i++) begin
            int op = $urandom_range(0, 3);
            logic [31:0] v = $urandom();
            case (op)
                0: wr(6'h08, v);
                1: wr(6'h0C, v);
                2: wr(6'($urandom_range(0, 63)), v);
                default: begin @(negedge clk); irq_in = v; end
            endcase
            settle(3);
            check_all("random");
        end

        // R1 reset mid-run clears enables and output
        wr(6'h08, 32'hFFFF_FFFF);
        @(negedge clk); irq_in = 32'hFFFF_FFFF;
        settle(3);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0; en_m = '0;
        rd(6'h08, d); chk("R1 enables after reset", d, 32'h0);
        chk("R1 out after reset", {31'd0, irq_out}, 32'h0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule